// File: doc/BRIEF.md
# Dual-Strobe Reversible Counter

This block is a modulo-16 counter with two separate strobe inputs. A rising edge on one strobe adds one to the count. A rising edge on the other strobe subtracts one. A fast system clock samples both strobes through synchronizer flops and detects their rising edges, so all state lives in ordinary clocked registers. A clear input forces the count to zero. An active-low load input copies a preset word into the count. Both take effect on the next system clock edge and win over any strobe activity.

Two active-low terminal outputs follow the low phase of the matching strobe, but only while the count sits at its end value. The carry output relates to the top value and the up strobe. The borrow output relates to zero and the down strobe. Wiring carry to the up strobe of a second instance, and borrow to its down strobe, builds a wider counter without any glue logic.

Top module: `updn_dual_counter`

## Requirements
- R1: A rising edge on `up_stb` adds one to `count`, and 15 wraps to 0. The new value appears at the third rising edge of `clk` after the strobe rises: two synchronizer stages, then the count register.
- R2: A rising edge on `dn_stb` subtracts one from `count`, and 0 wraps to 15, with the same latency as R1.
- R3: `count` holds when no strobe edge is detected. It also holds when rising edges on both strobes are detected in the same `clk` cycle.
- R4: `clr` high forces `count` to 0 at the next `clk` edge. It overrides `load_n` and both strobes.
- R5: `load_n` low with `clr` low copies `preset` into `count` at the next `clk` edge. A strobe edge detected in that same cycle is discarded.
- R6: `carry_n` is 0 exactly when `count` is 15 and the synchronized `up_stb` level is low. Otherwise it is 1.
- R7: `borrow_n` is 0 exactly when `count` is 0 and the synchronized `dn_stb` level is low. Otherwise it is 1.
- R8: A strobe held low through a clear or a load is still counted when it next rises, once the clear or load has been released.
- R9: `rst_n` low clears `count` to 0 at the next `clk` edge. It also sets the strobe history to high, so no edge is detected right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the strobes |
| rst_n | input | 1 | Synchronous active-low system reset |
| clr | input | 1 | Active-high clear of the count |
| load_n | input | 1 | Active-low parallel load |
| preset | input | 4 | Word copied into the count on load |
| up_stb | input | 1 | Count-up strobe, rising edge active |
| dn_stb | input | 1 | Count-down strobe, rising edge active |
| count | output | 4 | Current count |
| carry_n | output | 1 | Active-low carry, the up strobe's low phase at 15 |
| borrow_n | output | 1 | Active-low borrow, the down strobe's low phase at 0 |

## Verification
Two pairs of functions can fall in the same `clk` cycle.

The first pair is a detected strobe edge and a load. The bench raises `up_stb` and then times `load_n` low so that it is sampled at the exact edge where the rise is detected. The count must equal the preset, not the preset plus one.

The second pair is an up edge and a down edge. The bench releases both strobes together, and the count must not move.

A two-stage cascade then runs through a full 8-bit wrap in each direction against a bench model.

// File: rtl/updn_pkg.sv
// Package: shared operation code for the dual-strobe counter.
// Assumes: consumers decode exactly one operation per clock cycle.
package updn_pkg;
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_INC   = 3'd1,
        OP_DEC   = 3'd2,
        OP_LOAD  = 3'd3,
        OP_CLEAR = 3'd4
    } cnt_op_t;
endpackage

// File: rtl/strobe_sync.sv
// Module: strobe_sync
// Passes one asynchronous strobe through STAGES flops. It then compares the
// synchronized level with a history flop to flag a rising edge.
// Assumes: the strobe stays high and stays low for at least STAGES+1 clk cycles each.
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strb,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Purpose: first capture flop, set to idle-high on reset
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b1;
                else        sync_q[0] <= strb;
            end
        end else begin : g_next
            // Purpose: further metastability filtering
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b1;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Purpose: remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign lvl  = sync_q[STAGES-1];
    assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/count_core.sv
// Module: count_core
// Holds the count register and applies the single operation of each cycle.
// The priority order is clear, then load, then strobe edges.
// Assumes: up_rise and dn_rise are one-cycle pulses in the clk domain.
module count_core
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset,
    input  logic             up_rise,
    input  logic             dn_rise,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    cnt_op_t          op;
    logic [WIDTH-1:0] count_q;

    // Purpose: pick this cycle's operation by priority
    always_comb begin
        if (clr)                  op = OP_CLEAR;
        else if (!load_n)         op = OP_LOAD;
        else if (up_rise && dn_rise) op = OP_HOLD;
        else if (up_rise)         op = OP_INC;
        else if (dn_rise)         op = OP_DEC;
        else                      op = OP_HOLD;
    end

    // Purpose: update the count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            case (op)
                OP_CLEAR: count_q <= '0;
                OP_LOAD:  count_q <= preset;
                OP_INC:   count_q <= count_q + ONE;
                OP_DEC:   count_q <= count_q - ONE;
                default:  count_q <= count_q;
            endcase
        end
    end

    assign count = count_q;
endmodule

// File: rtl/tc_gen.sv
// Module: tc_gen
// Builds the active-low terminal outputs from the registered count and the
// synchronized strobe levels, so each output copies its strobe's low phase
// at the end value.
// Assumes: the inputs are registered, so the outputs are glitch-free per clk cycle.
module tc_gen #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic             carry_n,
    output logic             borrow_n
);
    // Purpose: detect the top value and zero
    logic at_top, at_zero;
    assign at_top  = &count;
    assign at_zero = ~|count;

    assign carry_n  = ~(at_top  & ~up_lvl);
    assign borrow_n = ~(at_zero & ~dn_lvl);
endmodule

// File: rtl/updn_dual_counter.sv
// Module: updn_dual_counter (top)
// Reversible counter driven by separate up and down strobes, oversampled by clk.
// Assumes: the strobes are slow compared with clk, and clr and load_n are synchronous to clk.
module updn_dual_counter #(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset,
    input  logic             up_stb,
    input  logic             dn_stb,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);
    logic up_lvl, up_rise, dn_lvl, dn_rise;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
        .clk(clk), .rst_n(rst_n), .strb(up_stb), .lvl(up_lvl), .rise(up_rise)
    );

    strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
        .clk(clk), .rst_n(rst_n), .strb(dn_stb), .lvl(dn_lvl), .rise(dn_rise)
    );

    count_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .preset(preset),
        .up_rise(up_rise), .dn_rise(dn_rise), .count(count)
    );

    tc_gen #(.WIDTH(WIDTH)) u_tc (
        .count(count), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
        .carry_n(carry_n), .borrow_n(borrow_n)
    );
endmodule

// File: rtl/updn_dual_counter_chk.sv
// Module: updn_dual_counter_chk
// Port-level checker. It keeps its own history of each strobe to predict
// the count. It is attached to every instance of the top by bind.
module updn_dual_counter_chk #(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             load_n,
    input logic [WIDTH-1:0] preset,
    input logic             up_stb,
    input logic             dn_stb,
    input logic [WIDTH-1:0] count,
    input logic             carry_n,
    input logic             borrow_n
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [SYNC_STAGES:0] up_h, dn_h;
    logic                 up_e, dn_e;

    // Purpose: shift history of both strobes, idle-high after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_h <= '1;
            dn_h <= '1;
        end else begin
            up_h <= {up_h[SYNC_STAGES-1:0], up_stb};
            dn_h <= {dn_h[SYNC_STAGES-1:0], dn_stb};
        end
    end

    assign up_e = up_h[SYNC_STAGES-1] & ~up_h[SYNC_STAGES];
    assign dn_e = dn_h[SYNC_STAGES-1] & ~dn_h[SYNC_STAGES];

    a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && up_e && !dn_e) |=> count == $past(count) + ONE);

    a_r2_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && dn_e && !up_e) |=> count == $past(count) - ONE);

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && (up_e == dn_e)) |=> $stable(count));

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);

    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load_n) |=> count == $past(preset));

    a_r6_carry_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (&count));

    a_r7_borrow_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (count == '0));
endmodule

bind updn_dual_counter updn_dual_counter_chk #(
    .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .preset(preset),
    .up_stb(up_stb), .dn_stb(dn_stb), .count(count),
    .carry_n(carry_n), .borrow_n(borrow_n)
);

// File: tb/updn_dual_counter_tb_top.sv
// Directed bench. dut_i is the low stage. hi_i is cascaded from dut_i's
// carry and borrow outputs.
module updn_dual_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       load_n = 1'b1, load_hi_n = 1'b1;
    logic [3:0] preset = 4'd0, preset_hi = 4'd0;
    logic       up_stb = 1'b1, dn_stb = 1'b1;
    logic [3:0] count, count_hi;
    logic       carry_n, borrow_n, carry_hi_n, borrow_hi_n;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    updn_dual_counter dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .preset(preset),
        .up_stb(up_stb), .dn_stb(dn_stb), .count(count),
        .carry_n(carry_n), .borrow_n(borrow_n)
    );

    updn_dual_counter hi_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_hi_n), .preset(preset_hi),
        .up_stb(carry_n), .dn_stb(borrow_n), .count(count_hi),
        .carry_n(carry_hi_n), .borrow_n(borrow_hi_n)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_up();
        up_stb = 1'b0; cyc(8);
        up_stb = 1'b1; cyc(8);
    endtask

    task automatic pulse_dn();
        dn_stb = 1'b0; cyc(8);
        dn_stb = 1'b1; cyc(8);
    endtask

    task automatic do_load(logic [3:0] v);
        preset = v; load_n = 1'b0; cyc(1);
        load_n = 1'b1; cyc(1);
    endtask

    task automatic t_reset();
        cyc(3);
        check("R9 count after reset", count, 0);
        check("R9 carry_n after reset", carry_n, 1);
        check("R9 borrow_n after reset", borrow_n, 1);
        rst_n = 1'b1; cyc(4);
        check("R9 no edge after reset", count, 0);
    endtask

    task automatic t_up_latency_wrap();
        do_load(4'd14);
        up_stb = 1'b0; cyc(8);
        up_stb = 1'b1; cyc(2);
        check("R1 no change before third edge", count, 14);
        cyc(1);
        check("R1 increment on third edge", count, 15);
        cyc(8);
        pulse_up();
        check("R1 wrap 15 to 0", count, 0);
    endtask

    task automatic t_down_wrap();
        do_load(4'd1);
        pulse_dn();
        check("R2 decrement", count, 0);
        pulse_dn();
        check("R2 wrap 0 to 15", count, 15);
    endtask

    task automatic t_hold_both();
        do_load(4'd7);
        cyc(10);
        check("R3 hold without edges", count, 7);
        up_stb = 1'b0; dn_stb = 1'b0; cyc(8);
        up_stb = 1'b1; dn_stb = 1'b1; cyc(8);
        check("R3 both edges same cycle hold", count, 7);
    endtask

    task automatic t_clear_priority();
        do_load(4'd9);
        preset = 4'd5; clr = 1'b1; load_n = 1'b0; cyc(1);
        clr = 1'b0; load_n = 1'b1; cyc(1);
        check("R4 clear overrides load", count, 0);
    endtask

    task automatic t_load_vs_edge();
        do_load(4'd2);
        up_stb = 1'b0; cyc(8);
        up_stb = 1'b1; cyc(2);
        preset = 4'd9; load_n = 1'b0; cyc(1);
        load_n = 1'b1; cyc(8);
        check("R5 load wins over same-cycle edge", count, 9);
    endtask

    task automatic t_low_through_load();
        dn_stb = 1'b0; cyc(6);
        do_load(4'd5);
        cyc(4);
        check("R8 load while strobe low", count, 5);
        dn_stb = 1'b1; cyc(8);
        check("R8 edge after load counted", count, 4);
    endtask

    task automatic t_terminal();
        do_load(4'd15);
        check("R6 carry_n high while up strobe high", carry_n, 1);
        up_stb = 1'b0; cyc(4);
        check("R6 carry_n low at 15 with up low", carry_n, 0);
        up_stb = 1'b1; cyc(8);
        check("R6 carry_n high after wrap", carry_n, 1);
        check("R7 borrow_n high with down strobe high", borrow_n, 1);
        dn_stb = 1'b0; cyc(4);
        check("R7 borrow_n low at 0 with down low", borrow_n, 0);
        dn_stb = 1'b1; cyc(8);
        check("R7 borrow_n high after wrap", borrow_n, 1);
        check("R2 wrap during borrow test", count, 15);
    endtask

    task automatic t_cascade();
        int model = 0;
        int bad = 0;
        preset = 4'd0; preset_hi = 4'd0;
        load_n = 1'b0; load_hi_n = 1'b0; cyc(1);
        load_n = 1'b1; load_hi_n = 1'b1; cyc(2);
        for (int i = 0; i < 256; i++) begin
            pulse_up();
            model = (model + 1) % 256;
            if ({count_hi, count} != model[7:0]) bad++;
        end
        check("R1 R6 cascade up full wrap mismatches", bad, 0);
        check("R1 cascade up final", {count_hi, count}, 0);
        bad = 0;
        for (int i = 0; i < 256; i++) begin
            pulse_dn();
            model = (model + 255) % 256;
            if ({count_hi, count} != model[7:0]) bad++;
        end
        check("R2 R7 cascade down full wrap mismatches", bad, 0);
        check("R2 cascade down final", {count_hi, count}, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_up_latency_wrap();
        t_down_wrap();
        t_hold_both();
        t_clear_priority();
        t_load_vs_edge();
        t_low_through_load();
        t_terminal();
        t_cascade();
        finish_run();
    end
endmodule